// File: doc/BRIEF.md
# CAN Frame Field Parser

The parser takes the destuffed bit stream of one CAN data or remote frame, one bit per strobe together with its position inside the frame, and turns it into decoded fields. It handles both identifier formats. In the base format, the control field and the data field follow the 11-bit identifier directly. In the extended format, an 18-bit identifier extension comes first, so both fields move back by twenty positions.

Each field is reported by a one-cycle valid pulse, and its value is held until the same field of the next frame is decoded. The parser runs a CRC-15 over the received frame start, arbitration, control and data bits, and compares the result with the transmitted checksum. It also reports whether the acknowledge slot was left recessive, and raises a flag if any fixed-recessive bit in the frame tail arrives dominant. Where the tail begins depends on the data length code and on whether the frame is a remote request. A final pulse marks the last end-of-frame bit, and the internal parse state then returns to its idle condition.

Top module: `can_frame_parser`

## Requirements
- R1: After reset, all valid pulses and all of `id_o`, `ide_o`, `srr_o`, `dlc_o`, `rtr_o`, `rb0_o`, `rb1_o`, `data_o`, `data_idx_o`, `crc_rx_o`, `crc_error_o`, `nack_o` and `form_error_o` are 0.
- R2: Every valid pulse lasts exactly one cycle. It appears in the cycle after the clock edge that accepts the frame bit closing its field. No pulse appears in a cycle after an edge where `bit_valid_i` was low.
- R3: If the bit at index 13 is 0 (dominant, base format), `id_valid_o` pulses for that bit. `id_o` then carries the 11 bits at indices 1..11, first bit as MSB, with bits 28..11 zero. `ide_o` and `srr_o` read 0.
- R4: If the bit at index 13 is 1 (extended format), `id_valid_o` pulses for index 31. `id_o` = base identifier << 18 | the 18 bits at indices 14..31 (first as MSB), `ide_o` = 1, and `srr_o` = the bit at index 12.
- R5: `ctrl_valid_o` pulses for the last bit of the length code, which is index 18 in base format and 38 in extended format. It presents `dlc_o` (4 bits from indices 15..18 or 35..38, MSB first) and `rtr_o` (index 12 in base format, index 32 in extended format; 1 means remote). It also presents `rb0_o` (index 14 or 34) and `rb1_o` (index 33, or 0 in base format). A recessive reserved bit is reported and raises no flag.
- R6: Data bytes follow the length code MSB first. `data_valid_o` pulses once per byte, with `data_o` holding the byte and `data_idx_o` counting up from 0.
- R7: A data frame carries min(`dlc_o`, 8) bytes. A remote frame carries no data bytes, whatever its length code. Let L be the index of the last data bit, or the last length-code bit when there is no data.
- R8: For index L+15, `crc_valid_o` pulses and `crc_rx_o` holds bits L+1..L+15 (MSB first). `crc_error_o` is set when that value differs from CRC-15 (polynomial 0x4599, initial 0, MSB-first shift) over indices 0..L.
- R9: For index L+17, `ack_valid_o` pulses and `nack_o` = the bit value (1 means not acknowledged).
- R10: `form_error_o` is set if the bit at L+16, L+18 or any of L+19..L+25 is 0, and it is visible when `frame_done_o` pulses.
- R11: `frame_done_o` pulses for index L+25 and the parse state is cleared. A new frame starting at index 0 is parsed from scratch, and index 0 clears `crc_error_o`, `nack_o` and `form_error_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_valid_i | input | 1 | A destuffed frame bit is present |
| bit_i | input | 1 | Bit value, 0 = dominant |
| bit_idx_i | input | IDX_W (7) | Position of the bit in the frame, 0 = start bit |
| id_valid_o | output | 1 | Identifier complete |
| id_o | output | 29 | Identifier, base format right-aligned |
| ide_o | output | 1 | 1 = extended format |
| srr_o | output | 1 | Substitute request bit (extended only) |
| ctrl_valid_o | output | 1 | Control field complete |
| dlc_o | output | 4 | Received data length code |
| rtr_o | output | 1 | 1 = remote frame |
| rb0_o | output | 1 | Reserved bit 0 as received |
| rb1_o | output | 1 | Reserved bit 1 as received |
| data_valid_o | output | 1 | Data byte complete |
| data_idx_o | output | BYTE_IDX_W (3) | Byte number in the data field |
| data_o | output | 8 | Data byte |
| crc_valid_o | output | 1 | Checksum field complete |
| crc_rx_o | output | 15 | Received checksum |
| crc_error_o | output | 1 | Checksum mismatch |
| ack_valid_o | output | 1 | Acknowledge slot sampled |
| nack_o | output | 1 | Acknowledge slot was recessive |
| form_error_o | output | 1 | Fixed-recessive tail bit seen dominant |
| frame_done_o | output | 1 | Last end-of-frame bit accepted |

## Verification
The properties rely on the bit source delivering `bit_idx_i` values of one frame strictly in order, from 0 up to the last end-of-frame bit, with no gaps. Each frame must end before the next one starts at 0. Idle cycles with `bit_valid_i` low may fall anywhere. The bench builds every frame from a bit array indexed exactly that way, and it inserts idle cycles at regular intervals without ever skipping or repeating an index. The stimulus sweeps both formats, both frame kinds and all sixteen length codes, with corrupted checksums, missing acknowledges and dominant tail bits injected on a fixed rotation.

// File: rtl/can_parse_pkg.sv
package can_parse_pkg;
  localparam int unsigned BASE_ID_W   = 11;
  localparam int unsigned EXT_ID_W    = 18;
  localparam int unsigned FULL_ID_W   = BASE_ID_W + EXT_ID_W;
  localparam int unsigned DLC_W       = 4;
  localparam int unsigned CRC_W       = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;

  // fixed bit positions, all relative to the start bit
  localparam int unsigned POS_BASE_END = 11;
  localparam int unsigned POS_B12      = 12;
  localparam int unsigned POS_IDE      = 13;
  localparam int unsigned STD_RB0      = 14;
  localparam int unsigned STD_DLC_END  = 18;
  localparam int unsigned EXT_EID_END  = 31;
  localparam int unsigned EXT_RTR      = 32;
  localparam int unsigned EXT_RB1      = 33;
  localparam int unsigned EXT_RB0      = 34;
  localparam int unsigned EXT_DLC_END  = 38;

  // tail offsets from the last data bit
  localparam int unsigned OFF_CRC_END  = 15;
  localparam int unsigned OFF_CRC_DEL  = 16;
  localparam int unsigned OFF_ACK      = 17;
  localparam int unsigned OFF_ACK_DEL  = 18;
  localparam int unsigned OFF_EOF_END  = 25;

  typedef enum logic [3:0] {
    F_NONE, F_SOF, F_BASE, F_B12, F_IDE, F_RB0, F_EID, F_RTR, F_RB1,
    F_DLC, F_DATA, F_CRC, F_CRC_DEL, F_ACK, F_ACK_DEL, F_EOF
  } field_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic [CRC_W-1:0] n;
    n = {c[CRC_W-2:0], 1'b0};
    if (b ^ c[CRC_W-1]) n = n ^ CRC_POLY;
    return n;
  endfunction
endpackage

// File: rtl/can_crc_unit.sv
module can_crc_unit
  import can_parse_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  // clr_i restarts from zero and absorbs the current bit in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '0;
    else if (en_i) crc_q <= crc_step(clr_i ? '0 : crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/can_field_decode.sv
module can_field_decode
  import can_parse_pkg::*;
#(
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned BYTE_IDX_W = 3
) (
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  ide_i,
  input  logic                  len_known_i,
  input  logic [IDX_W-1:0]      last_i,
  output field_e                field_o,
  output logic                  at_end_o,
  output logic                  crc_span_o,
  output logic [IDX_W-1:0]      dlc_end_o,
  output logic [BYTE_IDX_W-1:0] byte_idx_o
);
  localparam logic [IDX_W-1:0] P_BASE_END = IDX_W'(POS_BASE_END);
  localparam logic [IDX_W-1:0] P_B12      = IDX_W'(POS_B12);
  localparam logic [IDX_W-1:0] P_IDE      = IDX_W'(POS_IDE);
  localparam logic [IDX_W-1:0] P_SRB0     = IDX_W'(STD_RB0);
  localparam logic [IDX_W-1:0] P_EID_END  = IDX_W'(EXT_EID_END);
  localparam logic [IDX_W-1:0] P_ERTR     = IDX_W'(EXT_RTR);
  localparam logic [IDX_W-1:0] P_ERB1     = IDX_W'(EXT_RB1);
  localparam logic [IDX_W-1:0] P_ERB0     = IDX_W'(EXT_RB0);

  logic [IDX_W-1:0] off;

  always_comb begin
    dlc_end_o  = ide_i ? IDX_W'(EXT_DLC_END) : IDX_W'(STD_DLC_END);
    off        = idx_i - dlc_end_o - IDX_W'(1);
    byte_idx_o = BYTE_IDX_W'(off >> 3);
    field_o    = F_NONE;
    at_end_o   = 1'b0;
    if (idx_i == '0)                         field_o = F_SOF;
    else if (idx_i <= P_BASE_END)            field_o = F_BASE;
    else if (idx_i == P_B12)                 field_o = F_B12;
    else if (idx_i == P_IDE)                 field_o = F_IDE;
    else if (!ide_i && idx_i == P_SRB0)      field_o = F_RB0;
    else if (ide_i && idx_i <= P_EID_END) begin
      field_o  = F_EID;
      at_end_o = (idx_i == P_EID_END);
    end
    else if (ide_i && idx_i == P_ERTR)       field_o = F_RTR;
    else if (ide_i && idx_i == P_ERB1)       field_o = F_RB1;
    else if (ide_i && idx_i == P_ERB0)       field_o = F_RB0;
    else if (idx_i <= dlc_end_o) begin
      field_o  = F_DLC;
      at_end_o = (idx_i == dlc_end_o);
    end
    else if (len_known_i) begin
      if (idx_i <= last_i) begin
        field_o  = F_DATA;
        at_end_o = (off[2:0] == 3'b111);
      end
      else if (idx_i <= last_i + IDX_W'(OFF_CRC_END)) begin
        field_o  = F_CRC;
        at_end_o = (idx_i == last_i + IDX_W'(OFF_CRC_END));
      end
      else if (idx_i == last_i + IDX_W'(OFF_CRC_DEL)) field_o = F_CRC_DEL;
      else if (idx_i == last_i + IDX_W'(OFF_ACK))     field_o = F_ACK;
      else if (idx_i == last_i + IDX_W'(OFF_ACK_DEL)) field_o = F_ACK_DEL;
      else if (idx_i <= last_i + IDX_W'(OFF_EOF_END)) begin
        field_o  = F_EOF;
        at_end_o = (idx_i == last_i + IDX_W'(OFF_EOF_END));
      end
    end
    crc_span_o = field_o inside {F_SOF, F_BASE, F_B12, F_IDE, F_RB0, F_EID,
                                 F_RTR, F_RB1, F_DLC, F_DATA};
  end
endmodule

// File: rtl/can_frame_parser.sv
module can_frame_parser
  import can_parse_pkg::*;
#(
  parameter int unsigned MAX_BYTES  = 8,
  parameter int unsigned IDX_W      = $clog2(EXT_DLC_END + 8 * MAX_BYTES + OFF_EOF_END + 1),
  parameter int unsigned BYTE_IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bit_valid_i,
  input  logic                  bit_i,
  input  logic [IDX_W-1:0]      bit_idx_i,
  output logic                  id_valid_o,
  output logic [FULL_ID_W-1:0]  id_o,
  output logic                  ide_o,
  output logic                  srr_o,
  output logic                  ctrl_valid_o,
  output logic [DLC_W-1:0]      dlc_o,
  output logic                  rtr_o,
  output logic                  rb0_o,
  output logic                  rb1_o,
  output logic                  data_valid_o,
  output logic [BYTE_IDX_W-1:0] data_idx_o,
  output logic [7:0]            data_o,
  output logic                  crc_valid_o,
  output logic [CRC_W-1:0]      crc_rx_o,
  output logic                  crc_error_o,
  output logic                  ack_valid_o,
  output logic                  nack_o,
  output logic                  form_error_o,
  output logic                  frame_done_o
);
  // per-frame parse state
  logic                  ide_q, len_known_q, b12_q, rtr_q, rb0_q, rb1_q;
  logic [IDX_W-1:0]      last_q;
  logic [BASE_ID_W-1:0]  base_q;
  logic [EXT_ID_W-2:0]   eid_q;
  logic [DLC_W-2:0]      dlc_sh;
  logic [6:0]            byte_sh;
  logic [CRC_W-2:0]      crc_sh;

  field_e                field;
  logic                  at_end, crc_span;
  logic [IDX_W-1:0]      dlc_end;
  logic [BYTE_IDX_W-1:0] byte_idx;
  logic [CRC_W-1:0]      crc_calc;
  logic [DLC_W-1:0]      dlc_new, n_bytes;
  logic                  rtr_now;
  logic [CRC_W-1:0]      crc_rx_full;

  can_field_decode #(.IDX_W(IDX_W), .BYTE_IDX_W(BYTE_IDX_W)) i_decode (
    .idx_i       (bit_idx_i),
    .ide_i       (ide_q),
    .len_known_i (len_known_q),
    .last_i      (last_q),
    .field_o     (field),
    .at_end_o    (at_end),
    .crc_span_o  (crc_span),
    .dlc_end_o   (dlc_end),
    .byte_idx_o  (byte_idx)
  );

  can_crc_unit i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (bit_valid_i && crc_span),
    .clr_i  (field == F_SOF),
    .bit_i  (bit_i),
    .crc_o  (crc_calc)
  );

  always_comb begin
    dlc_new     = {dlc_sh, bit_i};
    rtr_now     = ide_q ? rtr_q : b12_q;
    crc_rx_full = {crc_sh, bit_i};
    if (rtr_now)                           n_bytes = '0;
    else if (dlc_new > DLC_W'(MAX_BYTES))  n_bytes = DLC_W'(MAX_BYTES);
    else                                   n_bytes = dlc_new;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ide_q        <= 1'b0;
      len_known_q  <= 1'b0;
      b12_q        <= 1'b0;
      rtr_q        <= 1'b0;
      rb0_q        <= 1'b0;
      rb1_q        <= 1'b0;
      last_q       <= '0;
      base_q       <= '0;
      eid_q        <= '0;
      dlc_sh       <= '0;
      byte_sh      <= '0;
      crc_sh       <= '0;
      id_valid_o   <= 1'b0;
      id_o         <= '0;
      ide_o        <= 1'b0;
      srr_o        <= 1'b0;
      ctrl_valid_o <= 1'b0;
      dlc_o        <= '0;
      rtr_o        <= 1'b0;
      rb0_o        <= 1'b0;
      rb1_o        <= 1'b0;
      data_valid_o <= 1'b0;
      data_idx_o   <= '0;
      data_o       <= '0;
      crc_valid_o  <= 1'b0;
      crc_rx_o     <= '0;
      crc_error_o  <= 1'b0;
      ack_valid_o  <= 1'b0;
      nack_o       <= 1'b0;
      form_error_o <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      id_valid_o   <= 1'b0;
      ctrl_valid_o <= 1'b0;
      data_valid_o <= 1'b0;
      crc_valid_o  <= 1'b0;
      ack_valid_o  <= 1'b0;
      frame_done_o <= 1'b0;
      if (bit_valid_i) begin
        case (field)
          F_SOF: begin
            ide_q        <= 1'b0;
            len_known_q  <= 1'b0;
            crc_error_o  <= 1'b0;
            nack_o       <= 1'b0;
            form_error_o <= 1'b0;
          end
          F_BASE: base_q <= {base_q[BASE_ID_W-2:0], bit_i};
          F_B12:  b12_q  <= bit_i;
          F_IDE: begin
            ide_q <= bit_i;
            if (!bit_i) begin
              id_valid_o <= 1'b1;
              id_o       <= FULL_ID_W'(base_q);
              ide_o      <= 1'b0;
              srr_o      <= 1'b0;
            end
          end
          F_EID: begin
            eid_q <= {eid_q[EXT_ID_W-3:0], bit_i};
            if (at_end) begin
              id_valid_o <= 1'b1;
              id_o       <= {base_q, eid_q, bit_i};
              ide_o      <= 1'b1;
              srr_o      <= b12_q;
            end
          end
          F_RTR: rtr_q <= bit_i;
          F_RB1: rb1_q <= bit_i;
          F_RB0: rb0_q <= bit_i;
          F_DLC: begin
            dlc_sh <= {dlc_sh[DLC_W-3:0], bit_i};
            if (at_end) begin
              ctrl_valid_o <= 1'b1;
              dlc_o        <= dlc_new;
              rtr_o        <= rtr_now;
              rb0_o        <= rb0_q;
              rb1_o        <= ide_q & rb1_q;
              last_q       <= dlc_end + (IDX_W'(n_bytes) << 3);
              len_known_q  <= 1'b1;
            end
          end
          F_DATA: begin
            byte_sh <= {byte_sh[5:0], bit_i};
            if (at_end) begin
              data_valid_o <= 1'b1;
              data_o       <= {byte_sh, bit_i};
              data_idx_o   <= byte_idx;
            end
          end
          F_CRC: begin
            crc_sh <= {crc_sh[CRC_W-3:0], bit_i};
            if (at_end) begin
              crc_valid_o <= 1'b1;
              crc_rx_o    <= crc_rx_full;
              crc_error_o <= (crc_rx_full != crc_calc);
            end
          end
          F_CRC_DEL, F_ACK_DEL: if (!bit_i) form_error_o <= 1'b1;
          F_ACK: begin
            ack_valid_o <= 1'b1;
            nack_o      <= bit_i;
          end
          F_EOF: begin
            if (!bit_i) form_error_o <= 1'b1;
            if (at_end) begin
              frame_done_o <= 1'b1;
              len_known_q  <= 1'b0;
              ide_q        <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_frame_parser_chk.sv
module can_frame_parser_chk
  import can_parse_pkg::*;
#(
  parameter int unsigned MAX_BYTES  = 8,
  parameter int unsigned BYTE_IDX_W = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bit_valid_i,
  input logic                  id_valid_o,
  input logic [FULL_ID_W-1:0]  id_o,
  input logic                  ide_o,
  input logic                  ctrl_valid_o,
  input logic [DLC_W-1:0]      dlc_o,
  input logic                  rtr_o,
  input logic                  data_valid_o,
  input logic [BYTE_IDX_W-1:0] data_idx_o,
  input logic                  crc_valid_o,
  input logic                  crc_error_o,
  input logic                  ack_valid_o,
  input logic                  nack_o,
  input logic                  frame_done_o
);
  logic [5:0] strobes;
  int         byte_cap;

  assign strobes  = {id_valid_o, ctrl_valid_o, data_valid_o, crc_valid_o, ack_valid_o, frame_done_o};
  assign byte_cap = (int'(dlc_o) > int'(MAX_BYTES)) ? int'(MAX_BYTES) : int'(dlc_o);

  a_r2_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobes));

  a_r2_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_valid_i) |-> strobes == '0);

  a_r3_base_id_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_o && !ide_o) |-> (id_o >> BASE_ID_W) == '0);

  a_r7_remote_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> !rtr_o);

  a_r7_byte_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> int'(data_idx_o) < byte_cap);

  a_r8_crc_flag_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_error_o) |-> crc_valid_o);

  a_r9_nack_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nack_o) |-> ack_valid_o);
endmodule

bind can_frame_parser can_frame_parser_chk #(
  .MAX_BYTES  (MAX_BYTES),
  .BYTE_IDX_W (BYTE_IDX_W)
) i_can_frame_parser_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_valid_i  (bit_valid_i),
  .id_valid_o   (id_valid_o),
  .id_o         (id_o),
  .ide_o        (ide_o),
  .ctrl_valid_o (ctrl_valid_o),
  .dlc_o        (dlc_o),
  .rtr_o        (rtr_o),
  .data_valid_o (data_valid_o),
  .data_idx_o   (data_idx_o),
  .crc_valid_o  (crc_valid_o),
  .crc_error_o  (crc_error_o),
  .ack_valid_o  (ack_valid_o),
  .nack_o       (nack_o),
  .frame_done_o (frame_done_o)
);

// File: tb/test_can_frame_parser.sv
`timescale 1ns/1ps
module test_can_frame_parser;
  localparam int IW = 7;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_valid = 1'b0;
  logic          bit_d = 1'b1;
  logic [IW-1:0] bit_idx = '0;
  logic          id_valid, ide, srr, ctrl_valid, rtr, rb0, rb1;
  logic          data_valid, crc_valid, crc_error, ack_valid, nack, form_error, frame_done;
  logic [28:0]   id;
  logic [3:0]    dlc;
  logic [BW-1:0] data_idx;
  logic [7:0]    data;
  logic [14:0]   crc_rx;

  always #4 clk = ~clk;

  can_frame_parser i_can_frame_parser (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bit_valid), .bit_i(bit_d), .bit_idx_i(bit_idx),
    .id_valid_o(id_valid), .id_o(id), .ide_o(ide), .srr_o(srr),
    .ctrl_valid_o(ctrl_valid), .dlc_o(dlc), .rtr_o(rtr), .rb0_o(rb0), .rb1_o(rb1),
    .data_valid_o(data_valid), .data_idx_o(data_idx), .data_o(data),
    .crc_valid_o(crc_valid), .crc_rx_o(crc_rx), .crc_error_o(crc_error),
    .ack_valid_o(ack_valid), .nack_o(nack), .form_error_o(form_error),
    .frame_done_o(frame_done)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // expected frame image
  bit          fb [0:127];
  bit          e_ide, e_rtr, e_srr, e_rb0, e_rb1, e_bad, e_nack;
  bit [3:0]    e_dlc;
  bit [10:0]   e_base;
  bit [17:0]   e_eid;
  bit [7:0]    e_bytes [0:7];
  bit [14:0]   e_crc_sent;
  int          e_nb, e_dend, e_last, e_finj, n_data;

  function automatic bit [14:0] crc_ref(input int upto);
    bit [14:0] c = '0;
    for (int i = 0; i <= upto; i++) begin
      bit fbk = fb[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fbk) c = c ^ 15'h4599;
    end
    return c;
  endfunction

  task automatic build(input int fnum, input bit ide_b, input bit rtr_b, input bit [3:0] dlc_b);
    int p;
    bit [14:0] c;
    e_ide = ide_b; e_rtr = rtr_b; e_dlc = dlc_b;
    e_base = 11'(fnum * 173 + 29);
    e_eid  = 18'(fnum * 40503 + 7);
    e_srr  = (fnum % 4) != 1;
    e_rb0  = (fnum % 3) == 0;   // recessive reserved bit accepted
    e_rb1  = (fnum % 5) == 2;
    e_bad  = (fnum % 5) == 1;
    e_nack = (fnum % 3) == 2;
    e_finj = fnum % 7;
    for (int j = 0; j < 8; j++) e_bytes[j] = 8'(fnum * 37 + j * 91 + 5);
    for (int i = 0; i < 128; i++) fb[i] = 1'b1;
    fb[0] = 1'b0;
    for (int i = 0; i < 11; i++) fb[1 + i] = e_base[10 - i];
    fb[12] = ide_b ? e_srr : rtr_b;
    fb[13] = ide_b;
    if (!ide_b) begin
      fb[14] = e_rb0; p = 15;
    end else begin
      for (int i = 0; i < 18; i++) fb[14 + i] = e_eid[17 - i];
      fb[32] = rtr_b; fb[33] = e_rb1; fb[34] = e_rb0; p = 35;
    end
    for (int i = 0; i < 4; i++) fb[p + i] = dlc_b[3 - i];
    e_dend = p + 3;
    e_nb   = rtr_b ? 0 : ((dlc_b > 8) ? 8 : int'(dlc_b));
    for (int j = 0; j < e_nb; j++)
      for (int i = 0; i < 8; i++) fb[e_dend + 1 + 8 * j + i] = e_bytes[j][7 - i];
    e_last = e_dend + 8 * e_nb;
    c = crc_ref(e_last);
    e_crc_sent = e_bad ? (c ^ 15'h0001) : c;
    for (int i = 0; i < 15; i++) fb[e_last + 1 + i] = e_crc_sent[14 - i];
    fb[e_last + 16] = (e_finj == 1) ? 1'b0 : 1'b1;
    fb[e_last + 17] = e_nack;
    fb[e_last + 18] = (e_finj == 2) ? 1'b0 : 1'b1;
    fb[e_last + 22] = (e_finj == 3) ? 1'b0 : 1'b1;
  endtask

  task automatic check_bit(input int k);
    bit [5:0] exp_s, act_s;
    bit id_at, dat_at;
    id_at  = e_ide ? (k == 31) : (k == 13);
    dat_at = (k > e_dend) && (k <= e_last) && (((k - e_dend) % 8) == 0);
    exp_s  = {id_at, k == e_dend, dat_at, k == e_last + 15, k == e_last + 17, k == e_last + 25};
    act_s  = {id_valid, ctrl_valid, data_valid, crc_valid, ack_valid, frame_done};
    chk("R2", $sformatf("strobes at bit %0d", k), act_s, exp_s);
    if (k == 0) begin   // R11 flags cleared by start bit
      chk("R11", "crc_error after start", crc_error, 0);
      chk("R11", "nack after start", nack, 0);
      chk("R11", "form_error after start", form_error, 0);
    end
    if (id_at && id_valid) begin
      if (!e_ide) begin
        chk("R3", "base id", id, {18'b0, e_base});
        chk("R3", "ide", ide, 0);
        chk("R3", "srr", srr, 0);
      end else begin
        chk("R4", "full id", id, {e_base, e_eid});
        chk("R4", "ide", ide, 1);
        chk("R4", "srr", srr, e_srr);
      end
    end
    if (k == e_dend && ctrl_valid) begin
      chk("R5", "dlc", dlc, e_dlc);
      chk("R5", "rtr", rtr, e_rtr);
      chk("R5", "rb0", rb0, e_rb0);
      chk("R5", "rb1", rb1, e_ide ? e_rb1 : 1'b0);
    end
    if (dat_at && data_valid) begin
      int j = (k - e_dend - 1) / 8;
      chk("R6", "data byte", data, e_bytes[j]);
      chk("R6", "data index", data_idx, j);
    end
    if (data_valid) n_data++;
    if (k == e_last + 15 && crc_valid) begin
      chk("R8", "crc received", crc_rx, e_crc_sent);
      chk("R8", "crc error", crc_error, e_bad);
    end
    if (k == e_last + 17 && ack_valid) chk("R9", "nack", nack, e_nack);
    if (k == e_last + 25 && frame_done) begin
      chk("R10", "form_error", form_error, (e_finj >= 1 && e_finj <= 3) ? 1 : 0);
      chk("R7", "data byte count", n_data, e_nb);
    end
  endtask

  task automatic send_frame();
    n_data = 0;
    for (int k = 0; k <= e_last + 25; k++) begin
      @(negedge clk);
      bit_valid = 1'b1; bit_d = fb[k]; bit_idx = IW'(k);
      @(posedge clk); #1;
      check_bit(k);
      if ((k % 5) == 4) begin
        @(negedge clk);
        bit_valid = 1'b0; bit_d = ~bit_d;
        @(posedge clk); #1;
        chk("R2", "idle cycle strobes",
            {id_valid, ctrl_valid, data_valid, crc_valid, ack_valid, frame_done}, 0);
      end
    end
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int fnum = 0;
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset",
        {id_valid, ctrl_valid, data_valid, crc_valid, ack_valid, frame_done}, 0);
    chk("R1", "id in reset", id, 0);
    chk("R1", "flags in reset", {ide, srr, rtr, rb0, rb1, crc_error, nack, form_error}, 0);
    chk("R1", "fields in reset", {dlc, data_idx, data, crc_rx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int x = 0; x < 2; x++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 16; d++) begin
          build(fnum, x[0], r[0], 4'(d));
          send_frame();
          fnum++;
        end
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule